// File: doc/BRIEF.md
# Fiber Port Fault Signalling Controller

This controller sits beside the physical-coding logic of a 100 Mb/s port that can run over copper or over an optical transceiver. Two comparator flags come from the analog signal-detect pin. One says the level is above the low threshold, the other says it is above the high threshold. The controller filters both flags and derives three results from them: the port mode, whether an optical signal is present, and whether the copper-only features (auto-negotiation and automatic crossover) may run.

A local fault exists when the port is in fiber mode, no optical signal is present, and fault generation is enabled. While a local fault exists, the controller takes over the transmit line in the gaps between frames. It sends a repeating pattern of 84 one bits followed by one zero bit. It never touches a frame in flight.

On the receive side, the controller looks for the same pattern from the link partner. After several back-to-back patterns it raises a remote-fault flag. It clears that flag after a programmable quiet interval in which no pattern completes.

Top module: `fxp_fault_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `fiber_mode`, `signal_ok`, `local_fault`, `tx_ovr`, `tx_bit` and `remote_fault` are 0, `an_xover_en` is 1 and `fault_en` is treated as its enabled value.
- R2: `fiber_mode` equals the filtered low-threshold flag. `signal_ok` is 1 only when both filtered flags are 1. A high flag with no low flag gives copper mode.
- R3: A filtered flag takes a new raw value only after the raw flag has differed from it on 16 consecutive clock edges. A shorter excursion leaves every output unchanged.
- R4: `local_fault` is 1 exactly when `fiber_mode` is 1, `signal_ok` is 0 and `fault_en` is 1. `fault_en` low suppresses all fault transmission.
- R5: While the override is active, `tx_bit` runs, one bit per clock, as 84 ones then a single zero, and repeats.
- R6: `tx_ovr` is 1 only when `local_fault` is 1 and `frame_active` is 0. A frame start drops the override in the same cycle. The next idle gap starts the pattern again from its first one bit.
- R7: `an_xover_en` is the inverse of `fiber_mode`.
- R8: A received pattern is a zero bit preceded by exactly 84 ones. `remote_fault` rises on the clock edge that samples the zero that ends the third consecutive pattern. A zero ending any other run length resets the pattern count.
- R9: `remote_fault` falls, and the pattern count resets, on the edge where the number of cycles since the last completed pattern reaches `rf_clear_len` (which is at least 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, one line bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| sd_lo_raw | input | 1 | Signal-detect above low threshold |
| sd_hi_raw | input | 1 | Signal-detect above high threshold |
| fault_en | input | 1 | Fault generation enable (register bit) |
| frame_active | input | 1 | A frame is being transmitted |
| rx_bit | input | 1 | Received line bit |
| rf_clear_len | input | 16 | Quiet cycles needed to clear the remote fault |
| fiber_mode | output | 1 | 1 = fiber mode, 0 = copper mode |
| signal_ok | output | 1 | Optical signal present |
| an_xover_en | output | 1 | Auto-negotiation and crossover allowed |
| local_fault | output | 1 | Local fault being signalled |
| tx_ovr | output | 1 | Transmit line taken over by the pattern |
| tx_bit | output | 1 | Pattern bit, valid when `tx_ovr` is 1 |
| remote_fault | output | 1 | Partner fault pattern seen |

## Verification
The signal-detect flags are exercised in four ways:
- a held fiber-with-signal level;
- a 10-cycle dip below 16, which must change nothing;
- a held loss of signal;
- a return to copper.

Together these separate the debounce from the classification. Frames are raised in the middle of a pattern to show that the override aborts and restarts from the first one bit, and the fault enable is dropped to show suppression. The receive stream carries:
- good patterns;
- a pattern one bit short, between good ones, to show that the count restarts;
- a long run of ones, to time the clear interval.

// File: rtl/fxp_pkg.sv
// Package: shared constants and the filtered signal-detect classification.
// Assumes one line bit per clock at the port rate.
package fxp_pkg;
    localparam int FXP_ONES_LEN  = 84;
    localparam int FXP_DEB_CYC   = 16;
    localparam int FXP_RF_PATS   = 3;
    localparam int FXP_CLR_W     = 16;

    typedef struct packed {
        logic fiber;    // low threshold exceeded
        logic present;  // high threshold exceeded as well
    } sd_class_t;
endpackage

// File: rtl/fxp_sd_filter.sv
// Module: fxp_sd_filter
// Debounces one comparator flag. The output follows the raw flag only after the
// raw flag has differed from it on DEB_CYC consecutive edges.
// Assumes the raw flag is already synchronised to clk.
module fxp_sd_filter #(
    parameter int DEB_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CNT_W = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;

    logic [CNT_W-1:0] cnt;

    // Count consecutive disagreeing samples; take the raw value at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            filt <= 1'b0;
        end else if (raw == filt) begin
            cnt <= '0;
        end else if (cnt == CNT_W'(DEB_CYC - 1)) begin
            cnt  <= '0;
            filt <= raw;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fxp_fault_tx.sv
// Module: fxp_fault_tx
// Generates the fault pattern (ONES_LEN ones then one zero, repeating) while
// enabled and outside frames. Any frame or disable returns the pattern to its start.
// Assumes frame_active rises before the first bit of a frame.
module fxp_fault_tx #(
    parameter int ONES_LEN = 84
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    input  logic frame_active,
    output logic tx_ovr,
    output logic tx_bit
);
    localparam int POS_W = $clog2(ONES_LEN + 1);
    localparam logic [POS_W-1:0] LAST = POS_W'(ONES_LEN);

    logic [POS_W-1:0] pos;

    // Override only in the idle gap while a fault is to be signalled.
    always_comb begin
        tx_ovr = fault && !frame_active;
        tx_bit = tx_ovr && (pos != LAST);
    end

    // Advance the bit position; restart on the zero bit or when the override stops.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_ovr) begin
            pos <= '0;
        end else if (pos == LAST) begin
            pos <= '0;
        end else begin
            pos <= pos + 1'b1;
        end
    end
endmodule

// File: rtl/fxp_fault_rx.sv
// Module: fxp_fault_rx
// Detects the partner's fault pattern in the received bit stream. It raises the
// flag after RF_PATS consecutive patterns and clears it after clr_len cycles with
// no completed pattern. Assumes clr_len >= 1.
module fxp_fault_rx #(
    parameter int ONES_LEN = 84,
    parameter int RF_PATS  = 3,
    parameter int CLR_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic [CLR_W-1:0] clr_len,
    output logic             remote_fault
);
    localparam int RUN_W = $clog2(ONES_LEN + 2);
    localparam int PAT_W = $clog2(RF_PATS + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;
    localparam logic [CLR_W-1:0] Q_MAX   = '1;

    logic [RUN_W-1:0] run;
    logic [PAT_W-1:0] pats;
    logic [CLR_W-1:0] quiet;
    logic             done;
    logic [CLR_W-1:0] quiet_nx;

    // A pattern completes on a zero that ends a run of exactly ONES_LEN ones.
    always_comb begin
        done     = !rx_bit && (run == RUN_W'(ONES_LEN));
        quiet_nx = (quiet == Q_MAX) ? quiet : quiet + 1'b1;
    end

    // Track the length of the current run of ones, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_bit) begin
            run <= '0;
        end else if (run != RUN_MAX) begin
            run <= run + 1'b1;
        end
    end

    // Count consecutive patterns, time the quiet interval, set and clear the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pats         <= '0;
            quiet        <= '0;
            remote_fault <= 1'b0;
        end else if (done) begin
            quiet <= '0;
            if (pats >= PAT_W'(RF_PATS - 1)) begin
                remote_fault <= 1'b1;
                pats         <= PAT_W'(RF_PATS);
            end else begin
                pats <= pats + 1'b1;
            end
        end else begin
            quiet <= quiet_nx;
            if (!rx_bit) begin
                pats <= '0;
            end
            if (remote_fault && (quiet_nx >= clr_len)) begin
                remote_fault <= 1'b0;
                pats         <= '0;
            end
        end
    end
endmodule

// File: rtl/fxp_fault_ctrl.sv
// Module: fxp_fault_ctrl (top)
// Fiber/copper mode selection and fault signalling for a 100 Mb/s port.
// It filters the two comparator flags, classifies the signal-detect level,
// drives the transmit override pattern and watches for the partner's pattern.
// Assumes all inputs are synchronous to clk.
module fxp_fault_ctrl
    import fxp_pkg::*;
#(
    parameter int ONES_LEN = FXP_ONES_LEN,
    parameter int DEB_CYC  = FXP_DEB_CYC,
    parameter int RF_PATS  = FXP_RF_PATS,
    parameter int CLR_W    = FXP_CLR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sd_lo_raw,
    input  logic             sd_hi_raw,
    input  logic             fault_en,
    input  logic             frame_active,
    input  logic             rx_bit,
    input  logic [CLR_W-1:0] rf_clear_len,
    output logic             fiber_mode,
    output logic             signal_ok,
    output logic             an_xover_en,
    output logic             local_fault,
    output logic             tx_ovr,
    output logic             tx_bit,
    output logic             remote_fault
);
    localparam int NFLAG = 2;

    logic [NFLAG-1:0] raw_flags;
    logic [NFLAG-1:0] filt_flags;
    sd_class_t        cls;

    assign raw_flags = {sd_hi_raw, sd_lo_raw};

    // One debounce filter per comparator flag.
    for (genvar g = 0; g < NFLAG; g++) begin : g_flt
        fxp_sd_filter #(.DEB_CYC(DEB_CYC)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_flags[g]),
            .filt (filt_flags[g])
        );
    end

    // Classify the filtered level and derive the mode and fault decisions.
    always_comb begin
        cls.fiber   = filt_flags[0];
        cls.present = filt_flags[0] && filt_flags[1];
        fiber_mode  = cls.fiber;
        signal_ok   = cls.present;
        an_xover_en = !cls.fiber;
        local_fault = cls.fiber && !cls.present && fault_en;
    end

    fxp_fault_tx #(.ONES_LEN(ONES_LEN)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault       (local_fault),
        .frame_active(frame_active),
        .tx_ovr      (tx_ovr),
        .tx_bit      (tx_bit)
    );

    fxp_fault_rx #(.ONES_LEN(ONES_LEN), .RF_PATS(RF_PATS), .CLR_W(CLR_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_bit      (rx_bit),
        .clr_len     (rf_clear_len),
        .remote_fault(remote_fault)
    );
endmodule

// File: rtl/fxp_fault_ctrl_chk.sv
// Module: fxp_fault_ctrl_chk
// Temporal checks on the controller's ports, attached by bind.
module fxp_fault_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic sd_lo_raw,
    input logic frame_active,
    input logic rx_bit,
    input logic fiber_mode,
    input logic an_xover_en,
    input logic local_fault,
    input logic tx_ovr,
    input logic tx_bit,
    input logic remote_fault
);
    // R4: a fault is only signalled in fiber mode
    a_r4_fault_needs_fiber: assert property (@(posedge clk) disable iff (!rst_n)
        local_fault |-> fiber_mode);
    // R6: the override never overlaps a frame
    a_r6_no_ovr_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        frame_active |-> !tx_ovr);
    // R6: each override interval starts with a one bit
    a_r6_start_with_one: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ovr) |-> tx_bit);
    // R5: a zero bit is followed by a one bit while the override continues
    a_r5_single_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovr && !tx_bit) |=> (!tx_ovr || tx_bit));
    // R7: copper features are off in fiber mode
    a_r7_an_off_fiber: assert property (@(posedge clk) disable iff (!rst_n)
        fiber_mode |-> !an_xover_en);
    // R3: the mode only moves toward the previously sampled raw flag
    a_r3_mode_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fiber_mode) |-> (fiber_mode == $past(sd_lo_raw)));
    // R8: the remote flag rises only on a sampled zero bit
    a_r8_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(remote_fault) |-> !$past(rx_bit));
endmodule

bind fxp_fault_ctrl fxp_fault_ctrl_chk u_chk (.*);

// File: tb/fxp_fault_ctrl_test.sv
module fxp_fault_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sd_lo_raw = 1'b0, sd_hi_raw = 1'b0, fault_en = 1'b1;
    logic        frame_active = 1'b0, rx_bit = 1'b1;
    logic [15:0] rf_clear_len = 16'd200;
    logic        fiber_mode, signal_ok, an_xover_en, local_fault, tx_ovr, tx_bit, remote_fault;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fxp_fault_ctrl uut (.*);

    // Behavioural reference state
    int  dcnt [2];
    bit  dflt [2];
    int  mpos, mrun, mpats, mquiet;
    bit  mrf;
    int  ovr_cycles = 0, rf_rises = 0;
    bit  prev_rf = 0;

    function automatic bit m_fiber();   return dflt[0]; endfunction
    function automatic bit m_sig();     return dflt[0] & dflt[1]; endfunction
    function automatic bit m_fault();   return m_fiber() & !m_sig() & fault_en; endfunction
    function automatic bit m_ovr();     return m_fault() & !frame_active; endfunction
    function automatic bit m_bit();     return m_ovr() & (mpos < 84); endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            dcnt[0] = 0; dcnt[1] = 0; dflt[0] = 0; dflt[1] = 0;
            mpos = 0; mrun = 0; mpats = 0; mquiet = 0; mrf = 0;
        end else begin
            bit raw [2];
            bit ovr_now;
            raw[0] = sd_lo_raw; raw[1] = sd_hi_raw;
            ovr_now = m_ovr();
            if (ovr_now) mpos = (mpos == 84) ? 0 : mpos + 1; else mpos = 0;
            if (!rx_bit && mrun == 84) begin
                mquiet = 0;
                mpats = mpats + 1;
                if (mpats >= 3) begin mrf = 1; mpats = 3; end
            end else begin
                if (mquiet < 65535) mquiet++;
                if (!rx_bit) mpats = 0;
                if (mrf && mquiet >= rf_clear_len) begin mrf = 0; mpats = 0; end
            end
            mrun = rx_bit ? ((mrun < 127) ? mrun + 1 : mrun) : 0;
            for (int i = 0; i < 2; i++) begin
                if (raw[i] == dflt[i]) dcnt[i] = 0;
                else if (dcnt[i] == 15) begin dcnt[i] = 0; dflt[i] = raw[i]; end
                else dcnt[i]++;
            end
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(rst_n ? "R2" : "R1", "fiber_mode", fiber_mode, m_fiber());
            chk(rst_n ? "R3" : "R1", "signal_ok", signal_ok, m_sig());
            chk("R7", "an_xover_en", an_xover_en, !m_fiber());
            chk(rst_n ? "R4" : "R1", "local_fault", local_fault, m_fault());
            chk("R6", "tx_ovr", tx_ovr, m_ovr());
            chk("R5", "tx_bit", tx_bit, m_bit());
            chk(rst_n ? "R8_R9" : "R1", "remote_fault", remote_fault, mrf);
            if (tx_ovr) ovr_cycles++;
            if (remote_fault && !prev_rf) rf_rises++;
            prev_rf = remote_fault;
        end
    end

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic rx_pat(int ones);
        for (int i = 0; i < ones; i++) begin rx_bit = 1'b1; step(1); end
        rx_bit = 1'b0; step(1);
        rx_bit = 1'b1;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: outputs still at reset values one cycle after release
        chk("R1", "fiber_mode after reset", fiber_mode, 1'b0);
        chk("R1", "remote_fault after reset", remote_fault, 1'b0);
        // R2: fiber with signal
        sd_lo_raw = 1; sd_hi_raw = 1;
        step(15);
        #3 chk("R3", "fiber_mode before 16 edges", fiber_mode, 1'b0);
        step(1);
        #3 chk("R2", "fiber_mode after 16 edges", fiber_mode, 1'b1);
        step(10);
        // R3: short dip ignored
        sd_hi_raw = 0; step(10); sd_hi_raw = 1; step(20);
        #3 chk("R3", "no fault after short dip", local_fault, 1'b0);
        // R4/R5: loss of signal
        sd_hi_raw = 0; step(220);
        // R6: frame in the middle of a pattern
        frame_active = 1; step(40); frame_active = 0; step(60);
        frame_active = 1; step(5); frame_active = 0; step(100);
        // R4: enable dropped
        fault_en = 0; step(50);
        #3 chk("R4", "no override when disabled", tx_ovr, 1'b0);
        fault_en = 1; step(30);
        // R8: receive patterns with a malformed one between
        rx_pat(84); rx_pat(84); rx_pat(83); rx_pat(84); rx_pat(84);
        #3 chk("R8", "flag low after two good", remote_fault, 1'b0);
        rx_pat(84);
        #3 chk("R8", "flag after third good", remote_fault, 1'b1);
        // R9: quiet ones until clear
        step(250);
        #3 chk("R9", "flag cleared after quiet", remote_fault, 1'b0);
        // R2/R7: back to copper; high flag alone stays copper
        sd_lo_raw = 0; sd_hi_raw = 1; step(40);
        #3 chk("R7", "copper features on", an_xover_en, 1'b1);
        chk("R5", "override seen", ovr_cycles > 170, 1'b1);
        chk("R8", "single rise of remote flag", rf_rises == 1, 1'b1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule